// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is one switch node of a two-dimensional mesh network-on-chip. It holds no packet storage. A packet that reaches the switch in one cycle is registered once and is driven out on some port in the next cycle. Nothing is ever held back. The switch has four neighbour links, numbered north 0, east 1, south 2 and west 3, and a local port to the resource at the node. The local port has an injection path and an ejection path. Each packet carries its destination coordinates and an age. The age grows by one on every hop.

In each cycle the accepted packets are served from oldest to youngest. A packet first tries a productive link, meaning one that brings it closer to its destination. When two productive links are free, the packet takes the one whose neighbour reports the lower load. A packet that finds no productive link free is deflected onto a free link instead of waiting.

The switch measures its own load as the number of packets arriving from its neighbours. It averages that count over the last four cycles and publishes the result as a stress value for its neighbours. Links that fall off the edge of the mesh are removed by a parameter. The router never drives them, and it ignores traffic that shows up on them.

Top module: `defl_router`

## Requirements
- R1: Every accepted packet appears exactly once, one clock after it is accepted. It comes out either on a link output or on the ejection output. A packet is accepted if it is valid on an available input link, or if it is injected while inj_ready is high.
- R2: The packet word is laid out as dst_x in bits [45:42], dst_y in [41:38], age in [37:32] and payload in [31:0]. Direction rules: dst_x greater than the node's X is productive towards east. dst_x less than the node's X is productive towards west. dst_y greater than the node's Y is productive towards north. dst_y less than the node's Y is productive towards south.
- R3: Packets are served in order of descending age. When two packets have the same age, the lower source index goes first. Link inputs use indices 0 to 3 and the injected packet is index 4. As a result, the oldest packet always gets a productive link when one exists.
- R4: A packet whose dst_x and dst_y both equal the node's coordinates is ejected on the local output. At most one packet is ejected per cycle, and that is the first such packet in service order. Any other packet addressed to the node is deflected.
- R5: inj_ready is combinational and high only when the number of valid packets on available input links is below the number of available links. An injection offered while inj_ready is low is not taken.
- R6: stress_out is the sum of the arrival counts of the last four cycles, divided by four and rounded down. The arrival count of a cycle is the number of valid packets on available input links, 0 to 4. stress_out reflects that count from the next clock on.
- R7: When more than one productive link is free, the packet takes the one with the lower nb_stress. When the stress values are equal, it takes the lower link index.
- R8: A deflected packet takes the free available link with the lowest index. Links marked in EDGE_MASK are never driven valid, and valid inputs on those links are ignored.
- R9: The age field of a packet leaving on a link is one higher than on arrival, and it saturates at 63. An ejected packet keeps its arrival age.
- R10: While reset is asserted, out_valid and ej_valid are low and stress_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Packet present on each neighbour input link |
| in_data | input | 4x46 | Packet word on each input link |
| nb_stress | input | 4x3 | Stress value reported by each neighbour |
| inj_valid | input | 1 | Local resource offers a packet |
| inj_data | input | 46 | Offered packet word |
| inj_ready | output | 1 | Offered packet is taken this cycle |
| out_valid | output | 4 | Packet driven on each output link |
| out_data | output | 4x46 | Packet word on each output link |
| ej_valid | output | 1 | Packet delivered to the local resource |
| ej_data | output | 46 | Delivered packet word |
| stress_out | output | 3 | Averaged load sent to the neighbours |

## Verification
Each arrival is visible at the ports one clock later, so a wrong choice inside the arbiter shows up on the very next cycle. It appears as a misplaced packet, a wrong age, a missing packet or a duplicated packet on the output links or the ejection port. A wrong service order or a wrong stress comparison moves a packet to another link in that same cycle. A fault in the load history gets no such immediate check. It shows only as a stress_out value that departs from the average of the last four arrival counts, and it may stay hidden for up to four cycles until the faulty entry changes the rounded sum.

// File: rtl/defl_pkg.sv
package defl_pkg;
  localparam int COORD_W  = 4;
  localparam int AGE_W    = 6;
  localparam int PAY_W    = 32;
  localparam int PKT_W    = 2*COORD_W + AGE_W + PAY_W;
  localparam int NLINK    = 4;
  localparam int NSRC     = NLINK + 1;
  localparam int CNT_W    = $clog2(NSRC + 1);
  localparam int RANK_W   = $clog2(NSRC);
  localparam int STRESS_W = 3;
  localparam int HIST_D   = 4;
  localparam int SUM_W    = STRESS_W + $clog2(HIST_D);

  localparam int PORT_N = 0;
  localparam int PORT_E = 1;
  localparam int PORT_S = 2;
  localparam int PORT_W = 3;

  typedef struct packed {
    logic [COORD_W-1:0] dst_x;
    logic [COORD_W-1:0] dst_y;
    logic [AGE_W-1:0]   age;
    logic [PAY_W-1:0]   payload;
  } pkt_t;
endpackage

// File: rtl/defl_route_calc.sv
module defl_route_calc
  import defl_pkg::*;
#(
  parameter logic [COORD_W-1:0] MY_X      = '0,
  parameter logic [COORD_W-1:0] MY_Y      = '0,
  parameter logic [NLINK-1:0]   EDGE_MASK = '0
) (
  input  pkt_t             pkt,
  output logic [NLINK-1:0] prod,
  output logic             here
);
  logic [NLINK-1:0] dir;

  always_comb begin
    dir = '0;
    if (pkt.dst_x > MY_X) dir[PORT_E] = 1'b1;
    if (pkt.dst_x < MY_X) dir[PORT_W] = 1'b1;
    if (pkt.dst_y > MY_Y) dir[PORT_N] = 1'b1;
    if (pkt.dst_y < MY_Y) dir[PORT_S] = 1'b1;
    prod = dir & ~EDGE_MASK;
    here = (pkt.dst_x == MY_X) && (pkt.dst_y == MY_Y);
  end
endmodule

// File: rtl/defl_arbiter.sv
module defl_arbiter
  import defl_pkg::*;
#(
  parameter logic [NLINK-1:0] EDGE_MASK = '0
) (
  input  logic [NSRC-1:0]                 src_valid,
  input  pkt_t [NSRC-1:0]                 src_pkt,
  input  logic [NSRC-1:0][NLINK-1:0]      src_prod,
  input  logic [NSRC-1:0]                 src_here,
  input  logic [NLINK-1:0][STRESS_W-1:0]  nb_stress,
  output logic [NLINK-1:0]                out_valid,
  output pkt_t [NLINK-1:0]                out_pkt,
  output logic                            ej_valid,
  output pkt_t                            ej_pkt
);
  logic [NSRC-1:0][RANK_W-1:0] rank;

  // service order: older first, lower source index on equal age
  always_comb begin
    for (int j = 0; j < NSRC; j++) begin
      rank[j] = '0;
      for (int i = 0; i < NSRC; i++) begin
        if (i != j && src_valid[i] &&
            (!src_valid[j] || src_pkt[i].age > src_pkt[j].age ||
             (src_pkt[i].age == src_pkt[j].age && i < j)))
          rank[j] = rank[j] + 1'b1;
      end
    end
  end

  logic [NLINK-1:0] taken;
  logic [NLINK-1:0] free_prod;
  logic [1:0]       pick;
  logic             found;
  logic             ej_taken;

  always_comb begin
    taken     = EDGE_MASK;
    ej_taken  = 1'b0;
    out_valid = '0;
    out_pkt   = '0;
    ej_valid  = 1'b0;
    ej_pkt    = '0;
    free_prod = '0;
    pick      = '0;
    found     = 1'b0;
    for (int r = 0; r < NSRC; r++) begin
      for (int i = 0; i < NSRC; i++) begin
        if (src_valid[i] && rank[i] == RANK_W'(r)) begin
          if (src_here[i] && !ej_taken) begin
            ej_taken = 1'b1;
            ej_valid = 1'b1;
            ej_pkt   = src_pkt[i];
          end else begin
            free_prod = src_prod[i] & ~taken;
            pick      = '0;
            found     = 1'b0;
            if (free_prod != '0) begin
              for (int p = 0; p < NLINK; p++)
                if (free_prod[p] && (!found || nb_stress[p] < nb_stress[pick])) begin
                  pick  = 2'(p);
                  found = 1'b1;
                end
            end else begin
              for (int p = 0; p < NLINK; p++)
                if (!taken[p] && !found) begin
                  pick  = 2'(p);
                  found = 1'b1;
                end
            end
            if (found) begin
              taken[pick]     = 1'b1;
              out_valid[pick] = 1'b1;
              out_pkt[pick]   = src_pkt[i];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/defl_stress.sv
module defl_stress
  import defl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [CNT_W-1:0]    load,
  output logic [STRESS_W-1:0] stress
);
  logic [HIST_D-1:0][STRESS_W-1:0] hist_q, hist_nxt;
  logic [SUM_W-1:0]                sum;

  always_comb begin
    hist_nxt = hist_q;
    if (upd_en) begin
      for (int k = HIST_D-1; k > 0; k--) hist_nxt[k] = hist_q[k-1];
      hist_nxt[0] = STRESS_W'(load);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nxt;
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < HIST_D; k++) sum = sum + SUM_W'(hist_q[k]);
    stress = STRESS_W'(sum >> $clog2(HIST_D));
  end
endmodule

// File: rtl/defl_router.sv
module defl_router
  import defl_pkg::*;
#(
  parameter logic [COORD_W-1:0] MY_X      = 4'd1,
  parameter logic [COORD_W-1:0] MY_Y      = 4'd1,
  parameter logic [NLINK-1:0]   EDGE_MASK = 4'b0000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NLINK-1:0]               in_valid,
  input  logic [NLINK-1:0][PKT_W-1:0]    in_data,
  input  logic [NLINK-1:0][STRESS_W-1:0] nb_stress,
  input  logic                           inj_valid,
  input  logic [PKT_W-1:0]               inj_data,
  output logic                           inj_ready,
  output logic [NLINK-1:0]               out_valid,
  output logic [NLINK-1:0][PKT_W-1:0]    out_data,
  output logic                           ej_valid,
  output logic [PKT_W-1:0]               ej_data,
  output logic [STRESS_W-1:0]            stress_out
);
  localparam int NUM_LINKS = NLINK - $countones(EDGE_MASK);

  logic [NLINK-1:0]          arr_valid;
  logic [CNT_W-1:0]          arr_cnt;
  logic [NSRC-1:0]           src_valid;
  pkt_t [NSRC-1:0]           src_pkt;
  logic [NSRC-1:0][NLINK-1:0] src_prod;
  logic [NSRC-1:0]           src_here;

  always_comb begin
    arr_valid = in_valid & ~EDGE_MASK;
    arr_cnt   = '0;
    for (int i = 0; i < NLINK; i++) arr_cnt = arr_cnt + CNT_W'(arr_valid[i]);
    inj_ready = (arr_cnt < CNT_W'(NUM_LINKS));
    for (int i = 0; i < NLINK; i++) src_pkt[i] = pkt_t'(in_data[i]);
    src_pkt[NLINK] = pkt_t'(inj_data);
    src_valid = {inj_valid & inj_ready, arr_valid};
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_route
    defl_route_calc #(.MY_X(MY_X), .MY_Y(MY_Y), .EDGE_MASK(EDGE_MASK)) u_route (
      .pkt  (src_pkt[g]),
      .prod (src_prod[g]),
      .here (src_here[g])
    );
  end

  logic [NLINK-1:0] arb_valid;
  pkt_t [NLINK-1:0] arb_pkt;
  logic             arb_ej_valid;
  pkt_t             arb_ej_pkt;

  defl_arbiter #(.EDGE_MASK(EDGE_MASK)) u_arb (
    .src_valid (src_valid),
    .src_pkt   (src_pkt),
    .src_prod  (src_prod),
    .src_here  (src_here),
    .nb_stress (nb_stress),
    .out_valid (arb_valid),
    .out_pkt   (arb_pkt),
    .ej_valid  (arb_ej_valid),
    .ej_pkt    (arb_ej_pkt)
  );

  defl_stress u_stress (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (1'b1),
    .load   (arr_cnt),
    .stress (stress_out)
  );

  // output link registers
  pkt_t [NLINK-1:0] out_d_nxt, out_d_q;
  logic [NLINK-1:0] out_v_q;
  pkt_t             ej_d_q;
  logic             ej_v_q;

  always_comb begin
    for (int p = 0; p < NLINK; p++) begin
      out_d_nxt[p] = arb_pkt[p];
      if (arb_pkt[p].age != '1) out_d_nxt[p].age = arb_pkt[p].age + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= '0;
      ej_v_q  <= 1'b0;
    end else begin
      out_v_q <= arb_valid;
      ej_v_q  <= arb_ej_valid;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NLINK; p++)
      if (arb_valid[p]) out_d_q[p] <= out_d_nxt[p];
    if (arb_ej_valid) ej_d_q <= arb_ej_pkt;
  end

  assign out_valid = out_v_q;
  assign out_data  = out_d_q;
  assign ej_valid  = ej_v_q;
  assign ej_data   = ej_d_q;
endmodule

// File: rtl/defl_router_chk.sv
module defl_router_chk
  import defl_pkg::*;
#(
  parameter logic [COORD_W-1:0] MY_X      = 4'd1,
  parameter logic [COORD_W-1:0] MY_Y      = 4'd1,
  parameter logic [NLINK-1:0]   EDGE_MASK = 4'b0000
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NLINK-1:0]               in_valid,
  input logic                           inj_valid,
  input logic                           inj_ready,
  input logic [NLINK-1:0]               out_valid,
  input logic                           ej_valid,
  input logic [PKT_W-1:0]               ej_data,
  input logic [STRESS_W-1:0]            stress_out
);
  localparam int NUM_LINKS = NLINK - $countones(EDGE_MASK);

  logic [CNT_W-1:0] acc_cnt;
  logic [CNT_W-1:0] arr_cnt;
  logic [CNT_W-1:0] leave_cnt;
  logic             prev_ok;

  always_comb begin
    arr_cnt   = CNT_W'($countones(in_valid & ~EDGE_MASK));
    acc_cnt   = arr_cnt + CNT_W'(inj_valid && inj_ready);
    leave_cnt = CNT_W'($countones(out_valid)) + CNT_W'(ej_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ok <= 1'b0;
    else        prev_ok <= 1'b1;
  end

  assert_conserve_R1: assert property (@(posedge clk) disable iff (!rst_n)
    prev_ok |-> (leave_cnt == $past(acc_cnt)));

  assert_eject_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ej_valid |-> (ej_data[45:42] == MY_X && ej_data[41:38] == MY_Y));

  assert_inject_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_cnt >= CNT_W'(NUM_LINKS)) |-> !inj_ready);

  assert_stress_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stress_out <= STRESS_W'(4));

  assert_edge_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid & EDGE_MASK) == '0);
endmodule

bind defl_router defl_router_chk #(
  .MY_X(MY_X), .MY_Y(MY_Y), .EDGE_MASK(EDGE_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .inj_valid  (inj_valid),
  .inj_ready  (inj_ready),
  .out_valid  (out_valid),
  .ej_valid   (ej_valid),
  .ej_data    (ej_data),
  .stress_out (stress_out)
);

// File: tb/defl_router_tb.sv
module defl_router_tb;
  import defl_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                     rst_n;
  logic [3:0]               in_valid;
  logic [3:0][PKT_W-1:0]    in_data;
  logic [3:0][STRESS_W-1:0] nb_stress;
  logic                     inj_valid;
  logic [PKT_W-1:0]         inj_data;
  logic                     inj_ready;
  logic [3:0]               out_valid;
  logic [3:0][PKT_W-1:0]    out_data;
  logic                     ej_valid;
  logic [PKT_W-1:0]         ej_data;
  logic [STRESS_W-1:0]      stress_out;

  // node (0,1) on the west edge
  defl_router #(.MY_X(4'd0), .MY_Y(4'd1), .EDGE_MASK(4'b1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .nb_stress(nb_stress), .inj_valid(inj_valid), .inj_data(inj_data),
    .inj_ready(inj_ready), .out_valid(out_valid), .out_data(out_data),
    .ej_valid(ej_valid), .ej_data(ej_data), .stress_out(stress_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // staged stimulus
  logic [3:0]               s_iv;
  logic [3:0][PKT_W-1:0]    s_id;
  logic [3:0][STRESS_W-1:0] s_ns;
  logic                     s_jv;
  logic [PKT_W-1:0]         s_jd;

  // reference expectations
  logic [3:0]            e_ov;
  logic [3:0][PKT_W-1:0] e_od;
  logic                  e_ejv;
  logic [PKT_W-1:0]      e_ejd;
  logic                  e_rdy;
  int                    e_stress;
  int                    hist[4];

  function automatic logic [PKT_W-1:0] mk(int dx, int dy, int age, int pay);
    return {4'(dx), 4'(dy), 6'(age), 32'(pay)};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model();
    bit               v[5];
    logic [PKT_W-1:0] d[5];
    bit               used[5];
    bit               tk[4];
    bit               ejt;
    int               arr;
    arr = 0;
    ejt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      v[i] = in_valid[i] && (i != 3);
      d[i] = in_data[i];
      arr += int'(v[i]);
      tk[i] = (i == 3);
    end
    e_rdy = (arr < 3);
    v[4] = inj_valid && e_rdy;
    d[4] = inj_data;
    for (int i = 0; i < 5; i++) used[i] = 1'b0;
    e_ov  = '0;
    e_ejv = 1'b0;
    for (int n = 0; n < 5; n++) begin
      int best;
      int dx;
      int dy;
      best = -1;
      for (int i = 0; i < 5; i++)
        if (v[i] && !used[i] && (best < 0 || d[i][37:32] > d[best][37:32])) best = i;
      if (best >= 0) begin
        used[best] = 1'b1;
        dx = int'(d[best][45:42]);
        dy = int'(d[best][41:38]);
        if (dx == 0 && dy == 1 && !ejt) begin
          ejt   = 1'b1;
          e_ejv = 1'b1;
          e_ejd = d[best];
        end else begin
          bit pr[4];
          int pick;
          int age;
          pr[0] = (dy > 1);
          pr[1] = (dx > 0);
          pr[2] = (dy < 1);
          pr[3] = 1'b0;
          pick = -1;
          for (int p = 0; p < 4; p++)
            if (pr[p] && !tk[p] && (pick < 0 || nb_stress[p] < nb_stress[pick])) pick = p;
          if (pick < 0)
            for (int p = 0; p < 4; p++)
              if (!tk[p] && pick < 0) pick = p;
          if (pick >= 0) begin
            age = int'(d[best][37:32]);
            if (age != 63) age++;
            tk[pick]   = 1'b1;
            e_ov[pick] = 1'b1;
            e_od[pick] = {d[best][45:38], 6'(age), d[best][31:0]};
          end
        end
      end
    end
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0]  = arr;
    e_stress = (hist[0] + hist[1] + hist[2] + hist[3]) / 4;
  endtask

  task automatic step();
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      chk(out_valid[p] == e_ov[p], "R1 out_valid", longint'(out_valid[p]), longint'(e_ov[p]));
      if (e_ov[p] && out_valid[p])
        chk(out_data[p] == e_od[p], "R2 out_data", longint'(out_data[p]), longint'(e_od[p]));
    end
    chk(ej_valid == e_ejv, "R4 ej_valid", longint'(ej_valid), longint'(e_ejv));
    if (e_ejv && ej_valid)
      chk(ej_data == e_ejd, "R4 ej_data", longint'(ej_data), longint'(e_ejd));
    chk(int'(stress_out) == e_stress, "R6 stress_out", longint'(stress_out), longint'(e_stress));
    in_valid  = s_iv;
    in_data   = s_id;
    nb_stress = s_ns;
    inj_valid = s_jv;
    inj_data  = s_jd;
    #1;
    model();
    chk(inj_ready == e_rdy, "R5 inj_ready", longint'(inj_ready), longint'(e_rdy));
  endtask

  task automatic idle();
    s_iv = '0;
    s_jv = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0; in_data = '0; nb_stress = '0; inj_valid = 1'b0; inj_data = '0;
    s_iv = '0; s_id = '0; s_ns = '0; s_jv = 1'b0; s_jd = '0;
    e_ov = '0; e_od = '0; e_ejv = 1'b0; e_ejd = '0; e_rdy = 1'b1; e_stress = 0;
    for (int k = 0; k < 4; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid == 4'b0, "R10 out_valid in reset", longint'(out_valid), 0);
    chk(ej_valid == 1'b0, "R10 ej_valid in reset", longint'(ej_valid), 0);
    chk(stress_out == 3'd0, "R10 stress in reset", longint'(stress_out), 0);
    rst_n = 1'b1;
    idle();
    step();

    // R2 single packet north-bound
    s_iv = 4'b0100; s_id[2] = mk(0, 3, 4, 32'h1111);
    step(); idle(); step();
    chk(out_valid == 4'b0001, "R2 north route", longint'(out_valid), 1);
    chk(out_data[0] == mk(0, 3, 5, 32'h1111), "R2 north data", longint'(out_data[0]), longint'(mk(0, 3, 5, 32'h1111)));

    // R7 stress picks east
    s_iv = 4'b0100; s_id[2] = mk(2, 3, 1, 32'h2222);
    s_ns[0] = 3'd3; s_ns[1] = 3'd1;
    step(); idle(); step();
    chk(out_valid == 4'b0010, "R7 lower stress east", longint'(out_valid), 2);
    // R7 stress picks north
    s_iv = 4'b0100; s_id[2] = mk(2, 3, 1, 32'h2223);
    s_ns[0] = 3'd0; s_ns[1] = 3'd2;
    step(); idle(); step();
    chk(out_valid == 4'b0001, "R7 lower stress north", longint'(out_valid), 1);
    // R7 equal stress, lower index
    s_iv = 4'b0100; s_id[2] = mk(2, 3, 1, 32'h2224);
    s_ns[0] = 3'd2; s_ns[1] = 3'd2;
    step(); idle(); step();
    chk(out_valid == 4'b0001, "R7 tie lower index", longint'(out_valid), 1);

    // R3 / R8 three packets contend for east, injection refused
    s_iv = 4'b0111;
    s_id[0] = mk(3, 1, 5, 32'hA0);
    s_id[1] = mk(3, 1, 9, 32'hA1);
    s_id[2] = mk(3, 1, 5, 32'hA2);
    s_jv = 1'b1; s_jd = mk(3, 1, 0, 32'hA4);
    step();
    chk(inj_ready == 1'b0, "R5 no room with three arrivals", longint'(inj_ready), 0);
    idle(); step();
    chk(out_valid == 4'b0111, "R8 deflect never west", longint'(out_valid), 7);
    chk(out_data[1][31:0] == 32'hA1, "R3 oldest gets east", longint'(out_data[1][31:0]), 32'hA1);
    chk(out_data[0][31:0] == 32'hA0, "R3 tie lower index deflects first", longint'(out_data[0][31:0]), 32'hA0);
    chk(out_data[2][31:0] == 32'hA2, "R8 next deflection south", longint'(out_data[2][31:0]), 32'hA2);

    // R4 two packets for this node
    s_iv = 4'b0011;
    s_id[0] = mk(0, 1, 2, 32'hB0);
    s_id[1] = mk(0, 1, 7, 32'hB1);
    step(); idle(); step();
    chk(ej_valid && ej_data == mk(0, 1, 7, 32'hB1), "R4 oldest ejected", longint'(ej_data), longint'(mk(0, 1, 7, 32'hB1)));
    chk(out_valid == 4'b0001 && out_data[0] == mk(0, 1, 3, 32'hB0), "R4 second deflected", longint'(out_data[0]), longint'(mk(0, 1, 3, 32'hB0)));

    // R5 injection with two arrivals
    s_iv = 4'b0011;
    s_id[0] = mk(3, 1, 1, 32'hC0);
    s_id[1] = mk(0, 3, 1, 32'hC1);
    s_jv = 1'b1; s_jd = mk(0, 0, 0, 32'hC4);
    step();
    chk(inj_ready == 1'b1, "R5 room with two arrivals", longint'(inj_ready), 1);
    idle(); step();
    chk(out_valid == 4'b0111 && out_data[2] == mk(0, 0, 1, 32'hC4), "R5 injected south", longint'(out_data[2]), longint'(mk(0, 0, 1, 32'hC4)));

    // R8 edge input ignored
    s_iv = 4'b1000; s_id[3] = mk(3, 3, 1, 32'hD3);
    step();
    chk(inj_ready == 1'b1, "R8 edge input not counted", longint'(inj_ready), 1);
    idle(); step();
    chk(out_valid == 4'b0000 && ej_valid == 1'b0, "R8 edge input dropped", longint'(out_valid), 0);

    // R9 age saturation
    s_iv = 4'b0001; s_id[0] = mk(0, 0, 63, 32'hE0);
    step(); idle(); step();
    chk(out_data[2][37:32] == 6'd63, "R9 age saturates", longint'(out_data[2][37:32]), 63);

    // R6 stress average
    repeat (4) step();
    chk(stress_out == 3'd0, "R6 stress after idle", longint'(stress_out), 0);
    for (int n = 0; n < 4; n++) begin
      s_iv = 4'b0111;
      s_id[0] = mk(1, 1, n, 32'hF0);
      s_id[1] = mk(0, 3, n, 32'hF1);
      s_id[2] = mk(0, 0, n, 32'hF2);
      step();
    end
    idle(); step();
    chk(stress_out == 3'd3, "R6 stress after four loads of three", longint'(stress_out), 3);

    // random traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      s_iv = 4'($urandom);
      for (int p = 0; p < 4; p++) begin
        s_id[p] = mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % 64), int'($urandom));
        s_ns[p] = 3'($urandom % 5);
      end
      s_jv = 1'($urandom);
      s_jd = mk(int'($urandom % 4), int'($urandom % 4), int'($urandom % 8), int'($urandom));
      step();
    end
    idle(); step(); step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule